// File: doc/BRIEF.md
# Streaming channel-major bit packer

This block sits on the capture path of a logic analyser running in uncompressed streaming mode. Every cycle in which the sample strobe is high, it takes one word holding the current level of up to 32 input channels. It transposes these words so that each enabled channel collects 16 successive samples into one 16-bit word. It then sends those words as bytes over a valid/ready stream, one word per enabled channel, visiting the channels in round-robin order. Channels that are disabled take up no space in the output stream.

The capture controller has two states: `CAP_IDLE` and `CAP_RUN`.
- `CAP_IDLE` moves to `CAP_RUN` on a start request, but only when the capture-mode input selects streaming (0x01) and the channel-enable mask is not zero. On that transition the mask is latched.
- Mode 0x00, which stores captures to local memory, is not served by this block.
- `CAP_RUN` returns to `CAP_IDLE` on a stop request.

A collector assembles each 16-sample group. When a group completes, it is handed to a holding buffer, so sampling carries on while the previous group drains (double buffering).

The emitter moves through three states:
- `EM_IDLE` goes to `EM_LOW` when the holding buffer is full, and selects the lowest enabled channel.
- `EM_LOW` goes to `EM_HIGH` when the low byte is accepted.
- `EM_HIGH` goes back to `EM_LOW` with the next higher enabled channel when the high byte is accepted. If no enabled channel is left, it goes to `EM_IDLE` and releases the buffer.

Top module: `stream_bit_packer`

## Requirements
- R1: A start request is accepted only when `cap_mode` is 0x01 and `ch_enable` is non-zero. Otherwise `running` stays low, and mode 0x00 never starts this block.
- R2: The channel mask is latched when a start is accepted. Changes on `ch_enable` while running have no effect on the output.
- R3: Each output word holds 16 consecutive accepted samples of one channel. Bit 0 is the oldest sample and bit 15 the newest.
- R4: Each word is sent little-endian: bits 7:0 first, then bits 15:8.
- R5: Each group produces exactly one word per enabled channel, in ascending channel index. Disabled channels produce nothing. The next group starts again at the lowest enabled channel.
- R6: Sampling continues while the previous group is being sent. No samples are lost if the holding buffer is released no later than the cycle in which the next group completes, including that very cycle.
- R7: A group that completes while the holding buffer is still occupied is dropped, and `overflow` is set. `overflow` stays set until the next accepted start clears it.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: Samples are ignored while not running. A stop discards a partially collected group, but a group already in the holding buffer is still sent.
- R10: After reset, `running`, `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_mode | input | 8 | Capture mode: 0x00 local memory, 0x01 streaming |
| start | input | 1 | Start request |
| stop | input | 1 | Stop request |
| ch_enable | input | NCH | Channel-enable mask, latched at start |
| smp_valid | input | 1 | Sample strobe |
| smp_bits | input | NCH | Sampled channel levels |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| running | output | 1 | Capture is active |
| overflow | output | 1 | Sticky flag: a group was lost |

## Verification
Two events can fall in the same cycle: completion of a 16-sample group in the collector, and the emitter's final-byte handshake, which frees the holding buffer. These are the case where a wrong priority either drops data or raises a false overflow.

The bench provokes this case as follows:
1. It stalls the output with one channel enabled until one group is held and the next group is one sample short.
2. It raises ready.
3. It delivers the 16th sample in exactly the cycle the high byte is accepted.

The run is judged correct if `overflow` stays low and both groups appear intact and in order on the byte stream. A separate stalled run checks the opposite outcome: the group is dropped and the flag is set.

// File: rtl/packer_pkg.sv
package packer_pkg;
    localparam int WORD_W = 16;
    localparam logic [7:0] MODE_TO_MEMORY = 8'h00;
    localparam logic [7:0] MODE_STREAMING = 8'h01;

    typedef enum logic {
        CAP_IDLE,
        CAP_RUN
    } cap_state_e;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_LOW,
        EM_HIGH
    } em_state_e;
endpackage

// File: rtl/pk_capture_ctrl.sv
module pk_capture_ctrl
    import packer_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [7:0]     cap_mode,
    input  logic           start,
    input  logic           stop,
    input  logic [NCH-1:0] ch_enable,
    output logic           running,
    output logic           start_accept,
    output logic [NCH-1:0] mask_q
);
    cap_state_e st_q, st_d;
    logic       start_ok;

    assign start_ok = start && (cap_mode == MODE_STREAMING) && (|ch_enable);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CAP_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_IDLE: if (start_ok) st_d = CAP_RUN;
            CAP_RUN:  if (stop)     st_d = CAP_IDLE;
            default:                st_d = CAP_IDLE;
        endcase
    end

    always_comb begin
        running      = (st_q == CAP_RUN);
        start_accept = (st_q == CAP_IDLE) && start_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '0;
        else if (start_accept) mask_q <= ch_enable;
    end

    assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(start && cap_mode == MODE_STREAMING && ch_enable != '0));

    assert_mask_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(mask_q));

    assert_reset_idle_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> !running);
endmodule

// File: rtl/pk_collector.sv
module pk_collector
    import packer_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       clear_ovf,
    input  logic                       smp_valid,
    input  logic [NCH-1:0]             smp_bits,
    input  logic [NCH-1:0]             run_mask,
    input  logic                       release_hold,
    output logic [NCH-1:0][WORD_W-1:0] hold_word,
    output logic [NCH-1:0]             hold_mask,
    output logic                       hold_full,
    output logic                       overflow
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]            cnt_q;
    logic [NCH-1:0][WORD_W-1:0]  acc_q, nxt_word;
    logic                        take, done, load;

    always_comb begin
        nxt_word = acc_q;
        for (int c = 0; c < NCH; c++) nxt_word[c][cnt_q] = smp_bits[c];
    end

    assign take = run && smp_valid;
    assign done = take && (cnt_q == LAST);
    assign load = done && (!hold_full || release_hold);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (take)      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (take) acc_q <= nxt_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_mask <= '0;
            hold_full <= 1'b0;
        end else if (load) begin
            hold_word <= nxt_word;
            hold_mask <= run_mask;
            hold_full <= 1'b1;
        end else if (release_hold) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_ovf)               overflow <= 1'b0;
        else if (done && hold_full && !release_hold) overflow <= 1'b1;
    end

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (overflow || $rose(run)));

    assert_release_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        release_hold |-> hold_full);

    assert_idle_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !overflow) |=> !overflow);
endmodule

// File: rtl/pk_emitter.sv
module pk_emitter
    import packer_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0][WORD_W-1:0] hold_word,
    input  logic [NCH-1:0]             hold_mask,
    input  logic                       hold_full,
    input  logic                       out_ready,
    output logic [7:0]                 out_data,
    output logic                       out_valid,
    output logic                       release_hold
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    em_state_e       st_q, st_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic [NCH-1:0]  above_mask;
    logic            more;

    function automatic logic [CH_W-1:0] lowest(input logic [NCH-1:0] v);
        lowest = '0;
        for (int i = NCH - 1; i >= 0; i--) if (v[i]) lowest = CH_W'(i);
    endfunction

    for (genvar i = 0; i < NCH; i++) begin : g_above
        assign above_mask[i] = hold_mask[i] && (CH_W'(i) > ch_q);
    end
    assign more = |above_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= EM_IDLE;
            ch_q <= '0;
        end else begin
            st_q <= st_d;
            ch_q <= ch_d;
        end
    end

    always_comb begin
        st_d = st_q;
        ch_d = ch_q;
        unique case (st_q)
            EM_IDLE: if (hold_full) begin
                st_d = EM_LOW;
                ch_d = lowest(hold_mask);
            end
            EM_LOW: if (out_ready) st_d = EM_HIGH;
            EM_HIGH: if (out_ready) begin
                if (more) begin
                    st_d = EM_LOW;
                    ch_d = lowest(above_mask);
                end else begin
                    st_d = EM_IDLE;
                end
            end
            default: st_d = EM_IDLE;
        endcase
    end

    always_comb begin
        out_valid    = (st_q == EM_LOW) || (st_q == EM_HIGH);
        out_data     = (st_q == EM_HIGH) ? hold_word[ch_q][15:8] : hold_word[ch_q][7:0];
        release_hold = (st_q == EM_HIGH) && out_ready && !more;
    end

    assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (hold_full && hold_mask[ch_q]));

    assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == EM_HIGH && out_ready && more) |=> (ch_q > $past(ch_q)));
endmodule

// File: rtl/stream_bit_packer.sv
module stream_bit_packer
    import packer_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [7:0]     cap_mode,
    input  logic           start,
    input  logic           stop,
    input  logic [NCH-1:0] ch_enable,
    input  logic           smp_valid,
    input  logic [NCH-1:0] smp_bits,
    input  logic           out_ready,
    output logic [7:0]     out_data,
    output logic           out_valid,
    output logic           running,
    output logic           overflow
);
    logic                       start_accept;
    logic [NCH-1:0]             mask_q;
    logic [NCH-1:0][WORD_W-1:0] hold_word;
    logic [NCH-1:0]             hold_mask;
    logic                       hold_full;
    logic                       release_hold;

    pk_capture_ctrl #(.NCH(NCH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_mode     (cap_mode),
        .start        (start),
        .stop         (stop),
        .ch_enable    (ch_enable),
        .running      (running),
        .start_accept (start_accept),
        .mask_q       (mask_q)
    );

    pk_collector #(.NCH(NCH)) u_coll (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (running),
        .clear_ovf    (start_accept),
        .smp_valid    (smp_valid),
        .smp_bits     (smp_bits),
        .run_mask     (mask_q),
        .release_hold (release_hold),
        .hold_word    (hold_word),
        .hold_mask    (hold_mask),
        .hold_full    (hold_full),
        .overflow     (overflow)
    );

    pk_emitter #(.NCH(NCH)) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_word    (hold_word),
        .hold_mask    (hold_mask),
        .hold_full    (hold_full),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .release_hold (release_hold)
    );
endmodule

// File: tb/tb_stream_bit_packer.sv
module tb_stream_bit_packer;
    localparam int NCH = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [7:0]     cap_mode;
    logic           start, stop, smp_valid, out_ready;
    logic [NCH-1:0] ch_enable, smp_bits;
    logic [7:0]     out_data;
    logic           out_valid, running, overflow;

    int errs = 0;
    int checks = 0;
    int rdy_mode = 1;
    logic [7:0]     rx_q[$];
    logic [7:0]     exp_q[$];
    logic [NCH-1:0] grp[16];

    always #2 clk = ~clk;

    stream_bit_packer #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .start(start), .stop(stop),
        .ch_enable(ch_enable), .smp_valid(smp_valid), .smp_bits(smp_bits),
        .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
        .running(running), .overflow(overflow)
    );

    always @(negedge clk) if (rdy_mode == 2) out_ready = ($urandom % 4) != 0;
    always @(posedge clk) if (rst_n && out_valid && out_ready) rx_q.push_back(out_data);

    task automatic check(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] word_of(input int ch);
        logic [15:0] w;
        for (int k = 0; k < 16; k++) w[k] = grp[k][ch];
        return w;
    endfunction

    task automatic push_group(input logic [NCH-1:0] mask);
        for (int ch = 0; ch < NCH; ch++)
            if (mask[ch]) begin
                logic [15:0] w;
                w = word_of(ch);
                exp_q.push_back(w[7:0]);
                exp_q.push_back(w[15:8]);
            end
    endtask

    task automatic send(input logic [NCH-1:0] w, input int gap);
        @(negedge clk); smp_valid = 1'b1; smp_bits = w;
        @(negedge clk); smp_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_start(input logic [7:0] mode, input logic [NCH-1:0] mask);
        @(negedge clk); cap_mode = mode; ch_enable = mask; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic drain();
        int quiet = 0;
        for (int i = 0; i < 4000 && quiet < 4; i++) begin
            @(negedge clk);
            if (out_valid) quiet = 0; else quiet++;
        end
    endtask

    task automatic compare(input string req);
        int n;
        check(req, "byte count", rx_q.size(), exp_q.size());
        n = (rx_q.size() < exp_q.size()) ? rx_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) check(req, $sformatf("byte %0d", i), rx_q[i], exp_q[i]);
        rx_q.delete();
        exp_q.delete();
    endtask

    task automatic run_groups(input logic [NCH-1:0] mask, input int ngroups,
                              input int gapbase, input int gaprand, input bit twiddle);
        for (int g = 0; g < ngroups; g++) begin
            for (int k = 0; k < 16; k++) begin
                grp[k] = $urandom;
                if (twiddle && k == 3) ch_enable = $urandom;
                send(grp[k], gapbase + int'($urandom % (gaprand + 1)));
            end
            push_group(mask);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R10: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [NCH-1:0] m;
        void'($urandom(32'h5EED_1234));
        rst_n = 0; cap_mode = 8'h00; start = 0; stop = 0; ch_enable = '0;
        smp_valid = 0; smp_bits = '0; out_ready = 1;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10", "running", running, 0);
        check("R10", "out_valid", out_valid, 0);
        check("R10", "overflow", overflow, 0);

        // R1: zero mask and memory mode are refused
        do_start(8'h01, '0);
        repeat (2) @(negedge clk);
        check("R1", "zero mask running", running, 0);
        do_start(8'h00, 32'hF);
        repeat (2) @(negedge clk);
        check("R1", "mode 0x00 running", running, 0);

        // R3 R4: directed single channel, known bit order
        do_start(8'h01, 32'h1);
        check("R1", "accepted start", running, 1);
        for (int k = 0; k < 16; k++) begin
            grp[k] = {31'h0, 16'hA5C3 >> k};
            send(grp[k], 1);
        end
        push_group(32'h1);
        drain();
        check("R4", "low byte first", rx_q.size() > 0 ? rx_q[0] : 8'hxx, 8'hC3);
        compare("R3");
        do_stop();

        // R5: sparse masks including the top channel
        do_start(8'h01, 32'h8000_0001);
        run_groups(32'h8000_0001, 2, 2, 2, 0);
        drain(); do_stop(); compare("R5");

        // R5: random masks, random ready
        rdy_mode = 2;
        for (int r = 0; r < 6; r++) begin
            m = $urandom;
            if (r == 0) m = '1;
            if (m == '0) m = 32'h10;
            do_start(8'h01, m);
            run_groups(m, 3, 7, 3, 0);
            drain(); do_stop(); compare("R5");
        end

        // R2: mask input wiggled while running
        m = 32'h0000_F00D;
        do_start(8'h01, m);
        run_groups(m, 2, 7, 3, 1);
        drain(); do_stop(); compare("R2");

        // R6: back-to-back groups with continuous sampling
        rdy_mode = 1; out_ready = 1;
        m = 32'h0101_0101;
        do_start(8'h01, m);
        run_groups(m, 4, 0, 0, 0);
        drain();
        check("R6", "no overflow continuous", overflow, 0);
        do_stop(); compare("R6");

        // R7: stalled output drops groups and flags overflow
        rdy_mode = 0; out_ready = 0;
        do_start(8'h01, 32'h1);
        run_groups(32'h1, 1, 0, 0, 0);
        for (int k = 0; k < 32; k++) send($urandom, 0);
        check("R7", "overflow set", overflow, 1);
        @(negedge clk); out_ready = 1;
        drain(); do_stop();
        compare("R7");
        check("R7", "overflow held after stop", overflow, 1);
        do_start(8'h01, 32'h1);
        check("R7", "overflow cleared by start", overflow, 0);
        do_stop();

        // R6: group completion in the same cycle as the final-byte release
        out_ready = 0;
        do_start(8'h01, 32'h1);
        run_groups(32'h1, 1, 0, 0, 0);
        for (int k = 0; k < 15; k++) begin
            grp[k] = $urandom;
            send(grp[k], 0);
        end
        grp[15] = $urandom;
        @(negedge clk); out_ready = 1;
        @(negedge clk); smp_valid = 1; smp_bits = grp[15];
        @(negedge clk); smp_valid = 0;
        push_group(32'h1);
        drain();
        check("R6", "no overflow same-cycle release", overflow, 0);
        do_stop(); compare("R6");

        // R9: stop drops a partial group; idle samples ignored
        rdy_mode = 2;
        do_start(8'h01, 32'h6);
        run_groups(32'h6, 1, 3, 2, 0);
        for (int k = 0; k < 5; k++) send($urandom, 2);
        do_stop();
        drain(); compare("R9");
        for (int k = 0; k < 16; k++) send($urandom, 0);
        repeat (20) @(negedge clk);
        check("R9", "bytes while idle", rx_q.size(), 0);
        check("R9", "running while idle", running, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule